// File: doc/BRIEF.md
# Segmented Counting Bloom Miss Filter

This block predicts misses in the last cache level before main memory. It is split into two halves that share no storage. The first half is a counter side. It sees the cache's line allocate and line evict events and keeps one small counter per hashed index. The second half is a presence side. It holds one bit per hashed index and answers processor lookups. Both halves fold the line address into an index through their own copy of the same XOR hash.

The only traffic between the halves is a registered bit-update channel. The counter side drives that channel only when a counter moves between zero and nonzero. A lookup returns a registered answer: "definitely absent", which is a safe miss, or "maybe present".

Allocations are meant to be reported when the miss is detected rather than at linefill. This way the presence bit is already set before the line arrives. A counter that would overflow is frozen by a sticky flag instead of wrapping, so the filter can never claim that a resident line is absent.

Top module: `bfm_miss_filter`

## Requirements
- R1: The index is the XOR of the line address cut into IDX_W-bit chunks, starting at bit 0, with the top chunk zero-padded. Counter side and presence side use the same fold.
- R2: Every lookup sampled with lk_valid high produces rsp_valid high exactly one clock later, and rsp_valid is low otherwise. In the response, rsp_maybe = 0 means definitely absent and rsp_maybe = 1 means maybe present.
- R3: An allocate (ev_evict = 0) adds one to the indexed counter. When the counter goes from 0 to 1, the presence bit is set.
- R4: An evict (ev_evict = 1) subtracts one from the indexed counter. The presence bit is cleared only when the counter goes from 1 to 0. A counter that stays nonzero leaves the bit at 1.
- R5: An evict that hits a counter already at 0 has no effect, and its index still reads as absent.
- R6: An allocate that hits a counter at its maximum (2^CNT_W - 1) sets a sticky flag and does not wrap. While the flag is set, later allocates and evicts on that index are ignored and the index reads as maybe present.
- R7: A lookup sampled one edge after the event's edge sees the old presence value. A lookup sampled two edges after the event's edge sees the new value. When the lookup and the bit write fall in the same cycle, the written value is forwarded to the lookup.
- R8: Events to the same index on consecutive cycles accumulate exactly as if they were spaced apart.
- R9: Synchronous active-high reset clears every counter, sticky flag and presence bit. While reset is high, rsp_valid is low.
- R10: The bit-update channel fires only on a zero crossing. It stays quiet for every other event and for idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Allocate/evict event present |
| ev_evict | input | 1 | 0 = allocate, 1 = evict |
| ev_addr | input | ADDR_W | Line address of the event |
| lk_valid | input | 1 | Lookup request present |
| lk_addr | input | ADDR_W | Line address to look up |
| rsp_valid | output | 1 | Lookup response valid, one cycle after the request |
| rsp_maybe | output | 1 | 0 = definitely absent, 1 = maybe present |

## Verification
A lookup answer is due on the clock edge after the one that samples the request. The bench therefore drives each request on a falling edge and reads the response on the next falling edge. An event reaches the presence bits over two registered stages: the counter read and update, then the bit-update channel. Sweeps after events first wait at least two idle cycles. The forwarding case is probed on purpose, with lookups sampled exactly one edge and exactly two edges after the event's edge, and expects the old value and the new value respectively. The bench's own model of counters and sticky flags is applied per event, so back-to-back bursts are checked against plain arithmetic.

// File: rtl/bfm_pkg.sv
package bfm_pkg;

  typedef enum logic {
    EV_ALLOC = 1'b0,
    EV_EVICT = 1'b1
  } ev_op_e;

  typedef enum logic [1:0] {
    XING_NONE = 2'd0,
    XING_RISE = 2'd1,
    XING_FALL = 2'd2
  } xing_e;

endpackage

// File: rtl/bfm_fold_hash.sv
module bfm_fold_hash #(
  parameter int ADDR_W = 27,
  parameter int IDX_W  = 11
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);

  localparam int NCH   = (ADDR_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W = NCH * IDX_W;

  logic [PAD_W-1:0] padded;
  logic [IDX_W-1:0] part [NCH];
  logic [IDX_W-1:0] acc  [NCH+1];

  always_comb begin
    padded = '0;
    padded[ADDR_W-1:0] = addr;
  end

  assign acc[0] = '0;

  for (genvar g = 0; g < NCH; g++) begin : g_chunk
    assign part[g]  = padded[g*IDX_W +: IDX_W];
    assign acc[g+1] = acc[g] ^ part[g];
  end

  assign idx = acc[NCH];

endmodule

// File: rtl/bfm_zero_detect.sv
module bfm_zero_detect
  import bfm_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  ev_op_e           op,
  input  logic [CNT_W-1:0] old_cnt,
  input  logic             old_sat,
  output logic [CNT_W-1:0] new_cnt,
  output logic             new_sat,
  output xing_e            xing
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_comb begin
    new_cnt = old_cnt;
    new_sat = old_sat;
    xing    = XING_NONE;
    if (!old_sat) begin
      if (op == EV_ALLOC) begin
        if (old_cnt == CNT_MAX) begin
          new_sat = 1'b1;
        end else begin
          new_cnt = old_cnt + CNT_ONE;
          if (old_cnt == '0) xing = XING_RISE;
        end
      end else begin
        if (old_cnt != '0) begin
          new_cnt = old_cnt - CNT_ONE;
          if (old_cnt == CNT_ONE) xing = XING_FALL;
        end
      end
    end
  end

endmodule

// File: rtl/bfm_counter_side.sv
module bfm_counter_side
  import bfm_pkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int IDX_W  = 11,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  ev_op_e            ev_op,
  input  logic [ADDR_W-1:0] ev_addr,
  output logic              upd_vld,
  output logic [IDX_W-1:0]  upd_idx,
  output logic              upd_val,
  output logic              sb_vld,
  output logic [IDX_W-1:0]  sb_idx,
  output logic              sb_evict,
  output logic [CNT_W-1:0]  sb_old_cnt,
  output logic              sb_old_sat,
  output logic [CNT_W-1:0]  sb_new_cnt,
  output logic              sb_new_sat
);

  localparam int DEPTH  = 1 << IDX_W;
  localparam int WORD_W = CNT_W + 1;

  logic [IDX_W-1:0]  ev_idx;
  logic [WORD_W-1:0] cmem [DEPTH];
  logic [WORD_W-1:0] rd_q;
  logic              sb_vld_q;
  logic [IDX_W-1:0]  sb_idx_q;
  ev_op_e            sb_op_q;
  logic              fwd_hit_q;
  logic [WORD_W-1:0] fwd_word_q;
  logic [WORD_W-1:0] old_word;
  logic [CNT_W-1:0]  new_cnt;
  logic              new_sat;
  xing_e             xing;
  logic              upd_vld_q;
  logic [IDX_W-1:0]  upd_idx_q;
  logic              upd_val_q;

  bfm_fold_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash (
    .addr (ev_addr),
    .idx  (ev_idx)
  );

  // Stage B operand: forward the word written last cycle when indices match
  assign old_word = fwd_hit_q ? fwd_word_q : rd_q;

  bfm_zero_detect #(.CNT_W(CNT_W)) u_zdet (
    .op      (sb_op_q),
    .old_cnt (old_word[CNT_W-1:0]),
    .old_sat (old_word[CNT_W]),
    .new_cnt (new_cnt),
    .new_sat (new_sat),
    .xing    (xing)
  );

  // Counter storage: one synchronous read port, one write port
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) cmem[i] <= '0;
      rd_q <= '0;
    end else begin
      if (sb_vld_q) cmem[sb_idx_q] <= {new_sat, new_cnt};
      rd_q <= cmem[ev_idx];
    end
  end

  // Stage A -> B pipeline and forwarding capture
  always_ff @(posedge clk) begin
    if (rst) begin
      sb_vld_q   <= 1'b0;
      sb_idx_q   <= '0;
      sb_op_q    <= EV_ALLOC;
      fwd_hit_q  <= 1'b0;
      fwd_word_q <= '0;
    end else begin
      sb_vld_q   <= ev_valid;
      sb_idx_q   <= ev_idx;
      sb_op_q    <= ev_op;
      fwd_hit_q  <= sb_vld_q && ev_valid && (sb_idx_q == ev_idx);
      fwd_word_q <= {new_sat, new_cnt};
    end
  end

  // Registered bit-update channel toward the presence side
  always_ff @(posedge clk) begin
    if (rst) begin
      upd_vld_q <= 1'b0;
      upd_idx_q <= '0;
      upd_val_q <= 1'b0;
    end else begin
      upd_vld_q <= sb_vld_q && (xing != XING_NONE);
      upd_idx_q <= sb_idx_q;
      upd_val_q <= (xing == XING_RISE);
    end
  end

  assign upd_vld    = upd_vld_q;
  assign upd_idx    = upd_idx_q;
  assign upd_val    = upd_val_q;
  assign sb_vld     = sb_vld_q;
  assign sb_idx     = sb_idx_q;
  assign sb_evict   = (sb_op_q == EV_EVICT);
  assign sb_old_cnt = old_word[CNT_W-1:0];
  assign sb_old_sat = old_word[CNT_W];
  assign sb_new_cnt = new_cnt;
  assign sb_new_sat = new_sat;

endmodule

// File: rtl/bfm_presence_vec.sv
module bfm_presence_vec #(
  parameter int ADDR_W = 27,
  parameter int IDX_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_vld,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic              upd_val,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              rsp_valid,
  output logic              rsp_maybe,
  output logic [IDX_W-1:0]  lk_idx
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] pvec;
  logic             same_slot;

  bfm_fold_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash (
    .addr (lk_addr),
    .idx  (lk_idx)
  );

  assign same_slot = upd_vld && (upd_idx == lk_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      pvec      <= '0;
      rsp_valid <= 1'b0;
      rsp_maybe <= 1'b0;
    end else begin
      if (upd_vld) pvec[upd_idx] <= upd_val;
      rsp_valid <= lk_valid;
      rsp_maybe <= same_slot ? upd_val : pvec[lk_idx];
    end
  end

endmodule

// File: rtl/bfm_miss_filter.sv
module bfm_miss_filter
  import bfm_pkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int IDX_W  = 11,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic              ev_evict,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              rsp_valid,
  output logic              rsp_maybe
);

  logic             upd_vld;
  logic [IDX_W-1:0] upd_idx;
  logic             upd_val;
  logic [IDX_W-1:0] lk_idx;
  logic             sb_vld;
  logic [IDX_W-1:0] sb_idx;
  logic             sb_evict;
  logic [CNT_W-1:0] sb_old_cnt;
  logic             sb_old_sat;
  logic [CNT_W-1:0] sb_new_cnt;
  logic             sb_new_sat;
  ev_op_e           ev_op;

  assign ev_op = ev_evict ? EV_EVICT : EV_ALLOC;

  bfm_counter_side #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .ev_valid   (ev_valid),
    .ev_op      (ev_op),
    .ev_addr    (ev_addr),
    .upd_vld    (upd_vld),
    .upd_idx    (upd_idx),
    .upd_val    (upd_val),
    .sb_vld     (sb_vld),
    .sb_idx     (sb_idx),
    .sb_evict   (sb_evict),
    .sb_old_cnt (sb_old_cnt),
    .sb_old_sat (sb_old_sat),
    .sb_new_cnt (sb_new_cnt),
    .sb_new_sat (sb_new_sat)
  );

  bfm_presence_vec #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_vec (
    .clk       (clk),
    .rst       (rst),
    .upd_vld   (upd_vld),
    .upd_idx   (upd_idx),
    .upd_val   (upd_val),
    .lk_valid  (lk_valid),
    .lk_addr   (lk_addr),
    .rsp_valid (rsp_valid),
    .rsp_maybe (rsp_maybe),
    .lk_idx    (lk_idx)
  );

endmodule

// File: rtl/bfm_miss_filter_chk.sv
module bfm_miss_filter_chk #(
  parameter int IDX_W = 11,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic             rsp_valid,
  input logic             rsp_maybe,
  input logic [IDX_W-1:0] lk_idx,
  input logic             upd_vld,
  input logic [IDX_W-1:0] upd_idx,
  input logic             upd_val,
  input logic             sb_vld,
  input logic [IDX_W-1:0] sb_idx,
  input logic             sb_evict,
  input logic [CNT_W-1:0] sb_old_cnt,
  input logic             sb_old_sat,
  input logic [CNT_W-1:0] sb_new_cnt,
  input logic             sb_new_sat
);

  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] CONE = CNT_W'(1);

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);
  p_rsp_only_on_req_r2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);
  p_rise_sets_bit_r3: assert property (@(posedge clk) disable iff (rst)
    (sb_vld && !sb_evict && !sb_old_sat && sb_old_cnt == '0)
      |=> (upd_vld && upd_val && upd_idx == $past(sb_idx)));
  p_fall_clears_bit_r4: assert property (@(posedge clk) disable iff (rst)
    (sb_vld && sb_evict && !sb_old_sat && sb_old_cnt == CONE)
      |=> (upd_vld && !upd_val && upd_idx == $past(sb_idx)));
  p_empty_evict_r5: assert property (@(posedge clk) disable iff (rst)
    (sb_vld && sb_evict && sb_old_cnt == '0) |-> (sb_new_cnt == '0));
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (sb_vld && !sb_evict && sb_old_cnt == CMAX) |-> (sb_new_cnt == CMAX && sb_new_sat));
  p_sticky_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (sb_vld && sb_old_sat) |-> (sb_new_sat && sb_new_cnt == sb_old_cnt));
  p_bypass_r7: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && upd_vld && upd_idx == lk_idx) |=> (rsp_maybe == $past(upd_val)));
  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !sb_vld |=> !upd_vld);
  p_quiet_no_cross_r10: assert property (@(posedge clk) disable iff (rst)
    (sb_vld && (sb_old_sat
                || (!sb_evict && sb_old_cnt != '0)
                || (sb_evict && sb_old_cnt != CONE))) |=> !upd_vld);
  p_reset_quiet_r9: assert property (@(posedge clk)
    rst_d |-> (!rsp_valid && !upd_vld));

endmodule

bind bfm_miss_filter bfm_miss_filter_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .lk_valid   (lk_valid),
  .rsp_valid  (rsp_valid),
  .rsp_maybe  (rsp_maybe),
  .lk_idx     (lk_idx),
  .upd_vld    (upd_vld),
  .upd_idx    (upd_idx),
  .upd_val    (upd_val),
  .sb_vld     (sb_vld),
  .sb_idx     (sb_idx),
  .sb_evict   (sb_evict),
  .sb_old_cnt (sb_old_cnt),
  .sb_old_sat (sb_old_sat),
  .sb_new_cnt (sb_new_cnt),
  .sb_new_sat (sb_new_sat)
);

// File: tb/bfm_miss_filter_tb_top.sv
module bfm_miss_filter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 12;
  localparam int IW   = 4;
  localparam int CW   = 2;
  localparam int NIDX = 1 << IW;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ev_valid = 1'b0;
  logic          ev_evict = 1'b0;
  logic [AW-1:0] ev_addr = '0;
  logic          lk_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic          rsp_valid;
  logic          rsp_maybe;

  int n_checks = 0;
  int n_fails  = 0;
  int m_cnt [NIDX];
  bit m_sat [NIDX];

  always #(CLK_PERIOD/2) clk = ~clk;

  bfm_miss_filter #(.ADDR_W(AW), .IDX_W(IW), .CNT_W(CW)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .ev_valid  (ev_valid),
    .ev_evict  (ev_evict),
    .ev_addr   (ev_addr),
    .lk_valid  (lk_valid),
    .lk_addr   (lk_addr),
    .rsp_valid (rsp_valid),
    .rsp_maybe (rsp_maybe)
  );

  function automatic int fold(int a);
    int r = 0;
    for (int c = 0; c * IW < AW; c++) r = r ^ ((a >> (c * IW)) & (NIDX - 1));
    return r;
  endfunction

  function automatic int addr_for(int idx, int salt);
    int hi  = (salt * 5 + idx) % 16;
    int mid = (salt * 11 + 3) % 16;
    return (hi << 8) | (mid << 4) | (idx ^ hi ^ mid);
  endfunction

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_clear;
    for (int i = 0; i < NIDX; i++) begin
      m_cnt[i] = 0;
      m_sat[i] = 0;
    end
  endtask

  // Event driven on a falling edge, sampled on the next rising edge
  task automatic send_ev(bit evict, int addr);
    int k = fold(addr);
    ev_valid = 1'b1;
    ev_evict = evict;
    ev_addr  = AW'(addr);
    @(negedge clk);
    ev_valid = 1'b0;
    if (!m_sat[k]) begin
      if (!evict) begin
        if (m_cnt[k] == CMAX) m_sat[k] = 1;
        else m_cnt[k]++;
      end else if (m_cnt[k] > 0) begin
        m_cnt[k]--;
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic look(int addr, bit exp, string tag);
    lk_valid = 1'b1;
    lk_addr  = AW'(addr);
    @(negedge clk);
    lk_valid = 1'b0;
    check(rsp_valid == 1'b1, {tag, " valid"}, int'(rsp_valid), 1);
    check(rsp_maybe == exp, tag, int'(rsp_maybe), int'(exp));
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < NIDX; i++)
      look(addr_for(i, i + 7), (m_cnt[i] != 0) || m_sat[i], tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    report();
  end

  initial begin
    model_clear();
    idle(3);
    // R9: no response during reset
    check(rsp_valid == 1'b0, "R9 rsp_valid in reset", int'(rsp_valid), 0);
    rst = 1'b0;
    idle(1);
    check(rsp_valid == 1'b0, "R2 no rsp without req", int'(rsp_valid), 0);
    sweep("R9 all clear after reset");

    // R1: fold of 0xA53 -> 3^5^A = C
    send_ev(1'b0, 12'hA53);
    idle(2);
    check(fold(12'hA53) == 12, "R1 bench fold", fold(12'hA53), 12);
    look(12'h00C, 1'b1, "R1 folded index set");
    look(12'h003, 1'b0, "R1 low chunk alone not set");
    look(12'hC00, 1'b1, "R1 top chunk alias");

    // R7: lookups one and two edges after the event's edge (index 5 fresh)
    send_ev(1'b0, 12'h005);
    look(12'h005, 1'b0, "R7 one edge later sees old");
    look(12'h005, 1'b1, "R7 two edges later sees new");
    send_ev(1'b1, 12'h005);
    look(12'h005, 1'b1, "R7 evict one edge later old");
    look(12'h005, 1'b0, "R7 evict two edges later new");

    // R5: evict on an empty index
    send_ev(1'b1, 12'h009);
    idle(2);
    look(12'h009, 1'b0, "R5 empty evict stays absent");
    send_ev(1'b0, 12'h009);
    idle(2);
    look(12'h009, 1'b1, "R5 counter not wrapped by empty evict");
    send_ev(1'b1, 12'h009);
    idle(2);
    look(12'h009, 1'b0, "R5 back to absent");

    // R8 + R4: back-to-back bursts on index 2
    send_ev(1'b0, 12'h002);
    send_ev(1'b0, 12'h112);
    send_ev(1'b0, 12'h222);
    send_ev(1'b1, 12'h002);
    send_ev(1'b1, 12'h332);
    idle(2);
    look(12'h002, 1'b1, "R8 burst leaves count 1");
    send_ev(1'b1, 12'h002);
    idle(2);
    look(12'h002, 1'b0, "R4 last evict clears");

    // R6: saturation on index 7, then evicts ignored
    for (int i = 0; i < CMAX + 1; i++) send_ev(1'b0, addr_for(7, i));
    for (int i = 0; i < CMAX + 3; i++) send_ev(1'b1, addr_for(7, i + 2));
    idle(2);
    look(12'h007, 1'b1, "R6 sticky keeps present");
    check(m_sat[7] == 1, "R6 model sticky", int'(m_sat[7]), 1);

    // R3/R4/R10: near-exhaustive mixed counts over every index
    for (int i = 0; i < NIDX; i++) begin
      for (int n = 0; n < (i * 3) % 5; n++) send_ev(1'b0, addr_for(i, n));
      for (int n = 0; n < (i * 7) % 4; n++) send_ev(1'b1, addr_for(i, n + 9));
    end
    idle(2);
    sweep("R3 R4 mixed sweep 1");
    for (int i = 0; i < NIDX; i++)
      if (i % 2 == 0) send_ev(1'b1, addr_for(i, 13));
      else send_ev(1'b0, addr_for(i, 14));
    idle(3);
    sweep("R10 mixed sweep 2");

    // R9: reset mid-run clears everything
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    model_clear();
    idle(1);
    sweep("R9 clear after mid-run reset");

    report();
  end

endmodule